// File: doc/BRIEF.md
# SMBus-aware I2C slave address recognizer

This block sits behind an I2C slave bit engine and decides whether an incoming address byte is acknowledged. When the engine has shifted in the eight address bits (seven address bits plus the read/write bit in bit 0), it pulses `addr_strobe` with the byte on `addr_byte`. The byte is compared against one programmed 7-bit own address and four reserved addresses, each with its own enable: general call, SMBus host, SMBus device default and SMBus alert response. One clock later the block presents a registered acknowledge decision, together with a code that says which address matched.

The block also keeps two status flags. The address-match flag is set by an acknowledged address. The stop flag is set by a STOP strobe from the engine. Each flag either stays set until a software clear strobe arrives, or is kept at zero by hardware when its automatic-clear control is on. The alert side drives an open-drain style alert output when the block acts as an SMBus device. As a host, it samples the alert line instead.

All pins are plain control and status signals. The address and STOP events are single-cycle strobes from the bit engine, which never waits on this block, so there is no valid/ready handshake and no back-pressure.

Top module: `smb_addr_recognizer`

## Requirements
- R1: With `en`=1, a byte whose bits [7:1] equal `own_addr` is acknowledged for either value of bit 0. It reports `match_code`=1, and this code takes priority over every reserved match.
- R2: The byte 8'h00 is acknowledged with `match_code`=2 only when `gc_en`=1. The byte 8'h01 is never a general-call match.
- R3: Address 7'b0001000 (bytes 8'h10 and 8'h11) is acknowledged with `match_code`=3 only when `host_en`=1.
- R4: Address 7'b1100001 (bytes 8'hC2 and 8'hC3) is acknowledged with `match_code`=4 only when `dev_en`=1.
- R5: With `host_en`=0, `en`=1 and `alert_en`=1, `alert_out_n` is 0, and address 7'b0001100 (bytes 8'h18 and 8'h19) is acknowledged with `match_code`=5. In any other case `alert_out_n` is 1 and that address is not acknowledged through the alert path.
- R6: With `host_en`=1, the alert-response address never produces `match_code`=5. In this mode `alert_seen` is 1 one clock after a cycle in which `en`=1, `alert_en`=1 and `alert_in_n`=0, and it is 0 otherwise.
- R7: `ack_valid` is 1 exactly in the cycle after `addr_strobe`. In that cycle `ack` carries the decision and `match_code` carries the matching source (0 means no match). When `ack_valid`=0, both `ack` and `match_code` are 0. All outputs are 0 after reset, except `alert_out_n`, which is 1.
- R8: With `addr_auto_clr`=0, an acknowledged address sets `match_flag` one clock after the strobe. The flag stays set until `addr_clr` is pulsed, and a set in the same cycle as a clear wins. With `addr_auto_clr`=1, the flag is held at 0.
- R9: With `stop_auto_clr`=0 and `en`=1, a `stop_strobe` sets `stop_flag` one clock later. The flag stays set until `stop_clr` is pulsed, and a set in the same cycle as a clear wins. With `stop_auto_clr`=1, the flag is held at 0.
- R10: With `en`=0, no byte is acknowledged, and both flags are 0 from the next clock on.
- R11: `addr_irq` equals `match_flag` AND `addr_irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Peripheral enable |
| own_addr | input | 7 | Programmed own address |
| gc_en | input | 1 | General-call enable |
| host_en | input | 1 | SMBus host mode / host address enable |
| dev_en | input | 1 | SMBus device-default address enable |
| alert_en | input | 1 | SMBus alert enable |
| addr_auto_clr | input | 1 | Keep the address-match flag cleared |
| stop_auto_clr | input | 1 | Keep the stop flag cleared |
| addr_irq_en | input | 1 | Address-match interrupt enable |
| addr_strobe | input | 1 | Address byte valid pulse from the bit engine |
| addr_byte | input | 8 | Received address byte, R/W in bit 0 |
| stop_strobe | input | 1 | STOP detected pulse from the bit engine |
| addr_clr | input | 1 | Software clear of the address-match flag |
| stop_clr | input | 1 | Software clear of the stop flag |
| alert_in_n | input | 1 | Sampled alert line, active low |
| ack_valid | output | 1 | Decision valid, one clock after the strobe |
| ack | output | 1 | 1 = acknowledge, 0 = not acknowledge |
| match_code | output | 3 | 0 none, 1 own, 2 general call, 3 host, 4 device default, 5 alert response |
| match_flag | output | 1 | Address-match status flag |
| stop_flag | output | 1 | Stop-detected status flag |
| addr_irq | output | 1 | Address-match interrupt request |
| alert_out_n | output | 1 | Alert drive, 0 = pull low, 1 = released |
| alert_seen | output | 1 | Host-mode alert observed |

## Verification
The bench builds the block with its default parameters: a 7-bit address and four reserved entries. This is the only configuration in which the SMBus reserved codes have their defined meaning. The parameters let the bench reach every reserved entry, each with its enable both set and clear. The bench also places the own address on top of reserved addresses to exercise the priority order, and it drives clear strobes in the same cycle as set events on both flags. Random stimulus changes the enables, the auto-clear controls and the peripheral enable from cycle to cycle, so that disabling the block while a flag is set, and switching auto-clear on while a flag is set, are both covered.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int ADDR_W  = 7;
  localparam int BYTE_W  = ADDR_W + 1;
  localparam int NUM_RES = 4;
  localparam int CODE_W  = 3;

  typedef enum logic [CODE_W-1:0] {
    MC_NONE   = 3'd0,
    MC_OWN    = 3'd1,
    MC_GCALL  = 3'd2,
    MC_HOST   = 3'd3,
    MC_DEVDEF = 3'd4,
    MC_ALERT  = 3'd5
  } match_code_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              rw0_only;
  } res_entry_t;

  // Reserved entry i reports code MC_GCALL + i; the index order is the priority order.
  function automatic res_entry_t res_entry(input int idx);
    res_entry_t e;
    case (idx)
      0:       begin e.addr = 7'b0000000; e.rw0_only = 1'b1; end
      1:       begin e.addr = 7'b0001000; e.rw0_only = 1'b0; end
      2:       begin e.addr = 7'b1100001; e.rw0_only = 1'b0; end
      default: begin e.addr = 7'b0001100; e.rw0_only = 1'b0; end
    endcase
    return e;
  endfunction
endpackage

// File: rtl/sar_decode.sv
module sar_decode
  import sar_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NR = NUM_RES
) (
  input  logic [AW:0]   rx_byte,
  input  logic [AW-1:0] own_addr,
  input  logic          en,
  input  logic [NR-1:0] res_en,
  output logic          hit,
  output match_code_e   code
);
  logic [NR-1:0] res_hit;
  logic          own_hit;

  assign own_hit = en && (rx_byte[AW:1] == own_addr);

  for (genvar i = 0; i < NR; i++) begin : g_res
    localparam res_entry_t ENT = res_entry(i);
    assign res_hit[i] = en && res_en[i] && (rx_byte[AW:1] == ENT.addr)
                        && (!ENT.rw0_only || !rx_byte[0]);
  end

  always_comb begin
    code = MC_NONE;
    for (int i = NR - 1; i >= 0; i--) begin
      if (res_hit[i]) code = match_code_e'(CODE_W'(i + 2));
    end
    if (own_hit) code = MC_OWN;
  end

  assign hit = own_hit || (|res_hit);
endmodule

// File: rtl/sar_flag.sv
module sar_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic hold_clear,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)          flag <= 1'b0;
    else if (hold_clear) flag <= 1'b0;
    else if (set)        flag <= 1'b1;
    else if (clr)        flag <= 1'b0;
  end

  // R8 / R9: a set event wins over a clear strobe in the same cycle
  a_r8_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set && !hold_clear) |=> flag);
  // R8 / R9: auto-clear keeps the flag at zero
  a_r8_r9_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    hold_clear |=> !flag);
  // R8 / R9: the flag only rises on a set event
  a_r8_r9_rise_on_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(set));
endmodule

// File: rtl/sar_alert.sv
module sar_alert (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic host_en,
  input  logic alert_en,
  input  logic alert_in_n,
  output logic alert_out_n,
  output logic ara_en,
  output logic alert_seen
);
  logic dev_alert;

  assign dev_alert   = en && !host_en && alert_en;
  assign alert_out_n = !dev_alert;
  assign ara_en      = dev_alert;

  always_ff @(posedge clk) begin
    if (!rst_n) alert_seen <= 1'b0;
    else        alert_seen <= en && host_en && alert_en && !alert_in_n;
  end

  // R6: host mode never pulls the alert line
  a_r6_host_release: assert property (@(posedge clk) disable iff (!rst_n)
    host_en |-> alert_out_n);
  // R6: an observed alert needs host mode with alert enabled
  a_r6_seen_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    alert_seen |-> $past(alert_en && host_en && en));
endmodule

// File: rtl/smb_addr_recognizer.sv
module smb_addr_recognizer
  import sar_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_en,
  input  logic              host_en,
  input  logic              dev_en,
  input  logic              alert_en,
  input  logic              addr_auto_clr,
  input  logic              stop_auto_clr,
  input  logic              addr_irq_en,
  input  logic              addr_strobe,
  input  logic [BYTE_W-1:0] addr_byte,
  input  logic              stop_strobe,
  input  logic              addr_clr,
  input  logic              stop_clr,
  input  logic              alert_in_n,
  output logic              ack_valid,
  output logic              ack,
  output logic [CODE_W-1:0] match_code,
  output logic              match_flag,
  output logic              stop_flag,
  output logic              addr_irq,
  output logic              alert_out_n,
  output logic              alert_seen
);
  logic               ara_en;
  logic [NUM_RES-1:0] res_en;
  logic               hit;
  match_code_e        code;
  match_code_e        code_q;

  sar_alert u_alert (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .host_en    (host_en),
    .alert_en   (alert_en),
    .alert_in_n (alert_in_n),
    .alert_out_n(alert_out_n),
    .ara_en     (ara_en),
    .alert_seen (alert_seen)
  );

  assign res_en = {ara_en, dev_en, host_en, gc_en};

  sar_decode #(.AW(ADDR_W), .NR(NUM_RES)) u_decode (
    .rx_byte (addr_byte),
    .own_addr(own_addr),
    .en      (en),
    .res_en  (res_en),
    .hit     (hit),
    .code    (code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_valid <= 1'b0;
      ack       <= 1'b0;
      code_q    <= MC_NONE;
    end else begin
      ack_valid <= addr_strobe;
      ack       <= addr_strobe && hit;
      code_q    <= addr_strobe ? code : MC_NONE;
    end
  end
  assign match_code = code_q;

  sar_flag u_match_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .set       (addr_strobe && hit),
    .clr       (addr_clr),
    .hold_clear(!en || addr_auto_clr),
    .flag      (match_flag)
  );

  sar_flag u_stop_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .set       (stop_strobe && en),
    .clr       (stop_clr),
    .hold_clear(!en || stop_auto_clr),
    .flag      (stop_flag)
  );

  assign addr_irq = match_flag && addr_irq_en;

  // R7: a decision follows every strobe one clock later
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strobe |=> ack_valid);
  // R7: a refused byte reports no source
  a_r7_nack_no_code: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack) |-> (match_code == MC_NONE));
  // R10: nothing is acknowledged while disabled
  a_r10_disabled_nack: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(en));
  // R8: the match flag rises together with an acknowledge
  a_r8_flag_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_flag) |-> ack);
endmodule

// File: tb/test_smb_addr_recognizer.sv
module test_smb_addr_recognizer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 0, gc_en = 0, host_en = 0, dev_en = 0, alert_en = 0;
  logic       addr_auto_clr = 0, stop_auto_clr = 0, addr_irq_en = 0;
  logic       addr_strobe = 0, stop_strobe = 0, addr_clr = 0, stop_clr = 0;
  logic       alert_in_n = 1;
  logic [6:0] own_addr = 7'h2A;
  logic [7:0] addr_byte = 8'h00;
  logic       ack_valid, ack, match_flag, stop_flag, addr_irq, alert_out_n, alert_seen;
  logic [2:0] match_code;

  int checks = 0, fails = 0;
  int e_mf = 0, e_sf = 0, e_seen = 0;

  always #5 clk = ~clk;

  smb_addr_recognizer i_smb_addr_recognizer (
    .clk(clk), .rst_n(rst_n), .en(en), .own_addr(own_addr), .gc_en(gc_en),
    .host_en(host_en), .dev_en(dev_en), .alert_en(alert_en),
    .addr_auto_clr(addr_auto_clr), .stop_auto_clr(stop_auto_clr),
    .addr_irq_en(addr_irq_en), .addr_strobe(addr_strobe), .addr_byte(addr_byte),
    .stop_strobe(stop_strobe), .addr_clr(addr_clr), .stop_clr(stop_clr),
    .alert_in_n(alert_in_n), .ack_valid(ack_valid), .ack(ack),
    .match_code(match_code), .match_flag(match_flag), .stop_flag(stop_flag),
    .addr_irq(addr_irq), .alert_out_n(alert_out_n), .alert_seen(alert_seen)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Expected match code from the requirements R1..R6
  function automatic int ref_code(input logic [7:0] b);
    if (!en) return 0;
    if (b[7:1] == own_addr) return 1;
    if (gc_en && b == 8'h00) return 2;
    if (host_en && b[7:1] == 7'b0001000) return 3;
    if (dev_en && b[7:1] == 7'b1100001) return 4;
    if (!host_en && alert_en && b[7:1] == 7'b0001100) return 5;
    return 0;
  endfunction

  function automatic string code_tag(input int c);
    case (c)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      default: return en ? "R7" : "R10";
    endcase
  endfunction

  // One clock: inputs are already driven; model the edge, then compare at the falling edge
  task automatic step();
    int    c_exp;
    int    s_exp;
    string t;
    c_exp = addr_strobe ? ref_code(addr_byte) : 0;
    s_exp = addr_strobe;
    t = addr_strobe ? code_tag(ref_code(addr_byte)) : "R7";
    if (!en || addr_auto_clr) e_mf = 0;
    else if (addr_strobe && c_exp != 0) e_mf = 1;
    else if (addr_clr) e_mf = 0;
    if (!en || stop_auto_clr) e_sf = 0;
    else if (stop_strobe) e_sf = 1;
    else if (stop_clr) e_sf = 0;
    e_seen = (en && host_en && alert_en && !alert_in_n) ? 1 : 0;
    @(posedge clk);
    @(negedge clk);
    chk("R7 ack_valid", int'(ack_valid), s_exp);
    chk({t, " ack"}, int'(ack), (c_exp != 0) ? 1 : 0);
    chk({t, " match_code"}, int'(match_code), c_exp);
    chk(en ? "R8 match_flag" : "R10 match_flag", int'(match_flag), e_mf);
    chk(en ? "R9 stop_flag" : "R10 stop_flag", int'(stop_flag), e_sf);
    chk("R11 addr_irq", int'(addr_irq), e_mf & int'(addr_irq_en));
    chk(host_en ? "R6 alert_out_n" : "R5 alert_out_n", int'(alert_out_n),
        (en && !host_en && alert_en) ? 0 : 1);
    chk("R6 alert_seen", int'(alert_seen), e_seen);
    addr_strobe = 0; stop_strobe = 0; addr_clr = 0; stop_clr = 0;
  endtask

  task automatic send(input logic [7:0] b);
    addr_byte = b; addr_strobe = 1; step(); step();
  endtask

  function automatic logic [7:0] pick_byte(input int unsigned r);
    case (r % 10)
      0: return {own_addr, 1'($urandom)};
      1: return 8'h00;
      2: return 8'h01;
      3: return 8'h10 | 8'(r[4]);
      4: return 8'hC2 | 8'(r[4]);
      5: return 8'h18 | 8'(r[4]);
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7: reset state
    chk("R7 reset ack_valid", int'(ack_valid), 0);
    chk("R7 reset match_code", int'(match_code), 0);
    chk("R7 reset flags", int'(match_flag | stop_flag), 0);
    chk("R7 reset alert_out_n", int'(alert_out_n), 1);
    rst_n = 1;
    step();

    // R10: disabled block refuses its own address
    en = 0; send({own_addr, 1'b0});
    en = 1; addr_irq_en = 1;
    // R1: own address, both R/W values
    send({own_addr, 1'b0}); send({own_addr, 1'b1});
    // R8: set wins over a simultaneous clear
    addr_byte = {own_addr, 1'b1}; addr_strobe = 1; addr_clr = 1; step();
    chk("R8 set wins", int'(match_flag), 1);
    addr_clr = 1; step();
    chk("R8 cleared by strobe", int'(match_flag), 0);
    // R2..R4: reserved addresses, enables off then on
    send(8'h00); send(8'h10); send(8'hC3);
    gc_en = 1; host_en = 1; dev_en = 1;
    send(8'h00); send(8'h01); send(8'h11); send(8'hC2);
    // R6: host mode with alert enabled ignores the alert-response address
    alert_en = 1; send(8'h18);
    alert_in_n = 0; step();
    chk("R6 alert seen host", int'(alert_seen), 1);
    alert_in_n = 1;
    // R5: device mode with alert drives low and accepts 0001100x
    host_en = 0; send(8'h19);
    chk("R5 alert drive", int'(alert_out_n), 0);
    // R1 priority: own address on top of a reserved one
    own_addr = 7'b1100001; send(8'hC2);
    chk("R1 priority code", int'(match_code), 0); // already past the valid cycle
    // R9: stop flag, set wins, then auto-clear
    stop_strobe = 1; stop_clr = 1; step();
    chk("R9 set wins", int'(stop_flag), 1);
    stop_auto_clr = 1; step();
    chk("R9 auto clear", int'(stop_flag), 0);
    stop_auto_clr = 0; stop_strobe = 1; step();
    // R10: disabling clears flags
    en = 0; step();
    chk("R10 flags cleared", int'(stop_flag | match_flag), 0);
    en = 1;

    // Random phase
    for (int n = 0; n < 3000; n++) begin
      int unsigned r;
      r = $urandom;
      if (r % 16 == 0) begin
        gc_en = r[4]; host_en = r[5]; dev_en = r[6]; alert_en = r[7];
        addr_auto_clr = (r[10:8] == 0); stop_auto_clr = (r[13:11] == 0);
        addr_irq_en = r[14]; own_addr = 7'($urandom);
      end
      en = (r[31:27] != 0);
      alert_in_n = r[15];
      addr_strobe = r[16] & r[17];
      addr_byte = pick_byte($urandom);
      stop_strobe = (r[20:18] == 0);
      addr_clr = (r[23:21] == 0);
      stop_clr = (r[26:24] == 0);
      step();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule